// File: doc/BRIEF.md
# Fast Monitoring Status Encoder

This block reduces a board's health to four status wires that a central fast-monitoring collector samples: a ready line, a busy line, a warning-overflow line and an out-of-sync line. There is no fifth wire for an error. An error is signalled by driving ready and busy high at the same time. Once an error is seen, it wins over the normal ready/busy encoding and stays until reset.

The board is ready when four things hold: every device has finished configuration, software has set its ready bit, the input alignment read has started, and data has reached the end of the pipeline. Any optical receiver that loses signal detect raises the error. An occupancy counter follows triggers accepted minus events sent. The overflow warning is driven from that count with a high and a low threshold, so it does not toggle around a single level. The out-of-sync line is the OR of the per-source flags.

All four outputs are registered. Each one responds on the first clock edge at which its inputs are sampled.

Top module: `fm_status_enc`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are rdy=0, bsy=1, wof=0, osy=0.
- R2: When there is no error, rdy=1 and bsy=0 follow one edge after all four conditions hold: every `cfg_done` bit is 1, the software ready bit is 1, the alignment flag is 1, and `pipe_filled` is 1.
- R3: When there is no error and any one of the four ready conditions is missing, the next edge gives rdy=0 and bsy=1.
- R4: A `sw_rdy_set` pulse sets the software ready bit and a `sw_rdy_clr` pulse clears it. Clear wins when both arrive in the same cycle. Otherwise the bit holds its value.
- R5: A one-cycle `align_seen` pulse sets the alignment flag, which then holds until reset.
- R6: If any `sig_detect` bit is 0 at an edge, the outputs from that edge on are rdy=1 and bsy=1 (the error code). This holds until reset, even after signal detect returns and whatever the ready conditions are.
- R7: The 12-bit occupancy count goes up by one on `trig_acc` alone and down by one on `evt_sent` alone. It does not change when both arrive together. It does not go below 0 or above 4095.
- R8: `fm_wof` goes to 1 on the edge at which the occupancy reaches `wof_hi` or more.
- R9: Once set, `fm_wof` stays at 1 until the occupancy falls below `wof_lo`.
- R10: `fm_osy` equals the OR of all `oos_flag` bits, one edge later.
- R11: Reset clears the software ready bit and the alignment flag. After reset, bsy stays at 1 even when the configuration and pipeline inputs are already good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cfg_done | input | N_CFG | Per-device configuration-done flags |
| sw_rdy_set | input | 1 | Pulse that sets the software ready bit |
| sw_rdy_clr | input | 1 | Pulse that clears the software ready bit |
| align_seen | input | 1 | Pulse marking the start of the alignment read |
| pipe_filled | input | 1 | Data has reached the pipeline output |
| sig_detect | input | N_LINK | Optical receiver signal-detect flags |
| oos_flag | input | N_OOS | Per-source out-of-sync flags |
| trig_acc | input | 1 | Trigger-accepted pulse |
| evt_sent | input | 1 | Event-sent-to-readout pulse |
| wof_hi | input | OCC_W | Occupancy level at which the warning is set |
| wof_lo | input | OCC_W | Occupancy level below which the warning is cleared |
| fm_rdy | output | 1 | Ready status line |
| fm_bsy | output | 1 | Busy status line |
| fm_wof | output | 1 | Warning-overflow status line |
| fm_osy | output | 1 | Out-of-sync status line |

## Verification
The ready AND is driven through a table in which each vector drops a different configuration bit or the pipeline flag. This shows that every term takes part and that no term is ORed in. Out-of-sync patterns are walked in the same table, with single-source and multi-source patterns. The occupancy is driven by simultaneous pulses, by the climb through the hysteresis band, by a decrement at zero and by a run past 4095. Each of these is seen through the warning line: a counter that wraps, double-counts or has no hysteresis gives a different wof value from a correct one. A signal-detect loss is held across restored inputs and a cleared software bit, so a level-following error is told apart from a latched one.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef struct packed {
    logic rdy;
    logic bsy;
    logic wof;
    logic osy;
  } fm_lines_t;

  // error overrides the ready/busy pair with the 1/1 code
  function automatic fm_lines_t fm_encode(input logic err, input logic ready,
                                          input logic wof, input logic osy);
    fm_lines_t l;
    l.rdy = err | ready;
    l.bsy = err | ~ready;
    l.wof = wof;
    l.osy = osy;
    return l;
  endfunction
endpackage

// File: rtl/fm_ready_track.sv
module fm_ready_track #(
  parameter int N_CFG = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CFG-1:0] cfg_done,
  input  logic             sw_set,
  input  logic             sw_clr,
  input  logic             align_seen,
  input  logic             pipe_filled,
  output logic             ready_nxt
);
  logic sw_q, al_q, sw_n, al_n;

  always_comb begin
    sw_n = sw_q;
    if (sw_set) sw_n = 1'b1;
    if (sw_clr) sw_n = 1'b0;
    al_n = al_q | align_seen;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q <= 1'b0;
      al_q <= 1'b0;
    end else begin
      sw_q <= sw_n;
      al_q <= al_n;
    end
  end

  assign ready_nxt = (&cfg_done) & sw_n & al_n & pipe_filled;
endmodule

// File: rtl/fm_err_latch.sv
module fm_err_latch #(
  parameter int N_LINK = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_LINK-1:0] sig_detect,
  output logic              err_nxt
);
  logic err_q;

  assign err_nxt = err_q | ~(&sig_detect);

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_nxt;
  end
endmodule

// File: rtl/fm_occ_track.sv
module fm_occ_track #(
  parameter int OCC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [OCC_W-1:0] hi_mark,
  input  logic [OCC_W-1:0] lo_mark,
  output logic [OCC_W-1:0] occ_q,
  output logic             wof_nxt
);
  localparam logic [OCC_W-1:0] OCC_MAX = {OCC_W{1'b1}};
  localparam logic [OCC_W-1:0] OCC_ONE = {{(OCC_W-1){1'b0}}, 1'b1};

  logic [OCC_W-1:0] occ_n;
  logic             wof_q;

  always_comb begin
    occ_n = occ_q;
    if (inc && !dec && occ_q != OCC_MAX) occ_n = occ_q + OCC_ONE;
    else if (dec && !inc && occ_q != '0) occ_n = occ_q - OCC_ONE;
    wof_nxt = wof_q;
    if (occ_n >= hi_mark)     wof_nxt = 1'b1;
    else if (occ_n < lo_mark) wof_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= '0;
      wof_q <= 1'b0;
    end else begin
      occ_q <= occ_n;
      wof_q <= wof_nxt;
    end
  end
endmodule

// File: rtl/fm_status_enc.sv
module fm_status_enc #(
  parameter int N_CFG  = 3,
  parameter int N_LINK = 4,
  parameter int N_OOS  = 4,
  parameter int OCC_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CFG-1:0]  cfg_done,
  input  logic              sw_rdy_set,
  input  logic              sw_rdy_clr,
  input  logic              align_seen,
  input  logic              pipe_filled,
  input  logic [N_LINK-1:0] sig_detect,
  input  logic [N_OOS-1:0]  oos_flag,
  input  logic              trig_acc,
  input  logic              evt_sent,
  input  logic [OCC_W-1:0]  wof_hi,
  input  logic [OCC_W-1:0]  wof_lo,
  output logic              fm_rdy,
  output logic              fm_bsy,
  output logic              fm_wof,
  output logic              fm_osy
);
  import fm_pkg::*;

  logic             ready_nxt, err_nxt, wof_nxt;
  logic [OCC_W-1:0] occ_q;
  fm_lines_t        lines_q;

  fm_ready_track #(.N_CFG(N_CFG)) u_ready (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .sw_set(sw_rdy_set),
    .sw_clr(sw_rdy_clr), .align_seen(align_seen), .pipe_filled(pipe_filled),
    .ready_nxt(ready_nxt)
  );

  fm_err_latch #(.N_LINK(N_LINK)) u_err (
    .clk(clk), .rst(rst), .sig_detect(sig_detect), .err_nxt(err_nxt)
  );

  fm_occ_track #(.OCC_W(OCC_W)) u_occ (
    .clk(clk), .rst(rst), .inc(trig_acc), .dec(evt_sent),
    .hi_mark(wof_hi), .lo_mark(wof_lo), .occ_q(occ_q), .wof_nxt(wof_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '{rdy: 1'b0, bsy: 1'b1, wof: 1'b0, osy: 1'b0};
    else     lines_q <= fm_encode(err_nxt, ready_nxt, wof_nxt, |oos_flag);
  end

  assign fm_rdy = lines_q.rdy;
  assign fm_bsy = lines_q.bsy;
  assign fm_wof = lines_q.wof;
  assign fm_osy = lines_q.osy;
endmodule

// File: rtl/fm_status_enc_chk.sv
module fm_status_enc_chk #(
  parameter int N_LINK = 4,
  parameter int N_OOS  = 4,
  parameter int OCC_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [N_LINK-1:0] sig_detect,
  input logic [N_OOS-1:0]  oos_flag,
  input logic              trig_acc,
  input logic              evt_sent,
  input logic [OCC_W-1:0]  occ_q,
  input logic              fm_rdy,
  input logic              fm_bsy,
  input logic              fm_wof,
  input logic              fm_osy
);
  a_r1_reset_lines: assert property (@(posedge clk)
    rst |=> (!fm_rdy && fm_bsy && !fm_wof && !fm_osy));

  a_r6_err_raise: assert property (@(posedge clk) disable iff (rst)
    !(&sig_detect) |=> (fm_rdy && fm_bsy));

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (fm_rdy && fm_bsy) |=> (fm_rdy && fm_bsy));

  a_r10_osy_follow: assert property (@(posedge clk) disable iff (rst)
    (|oos_flag) |=> fm_osy);

  a_r10_osy_quiet: assert property (@(posedge clk) disable iff (rst)
    !(|oos_flag) |=> !fm_osy);

  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0 && evt_sent && !trig_acc) |=> (occ_q == '0));

  a_r7_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (trig_acc && evt_sent) |=> $stable(occ_q));
endmodule

bind fm_status_enc fm_status_enc_chk #(.N_LINK(N_LINK), .N_OOS(N_OOS), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .sig_detect(sig_detect), .oos_flag(oos_flag),
  .trig_acc(trig_acc), .evt_sent(evt_sent), .occ_q(u_occ.occ_q),
  .fm_rdy(fm_rdy), .fm_bsy(fm_bsy), .fm_wof(fm_wof), .fm_osy(fm_osy)
);

// File: tb/test_fm_status_enc.sv
`timescale 1ns/1ps
module test_fm_status_enc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_done = 3'b111;
  logic        sw_rdy_set = 1'b0, sw_rdy_clr = 1'b0, align_seen = 1'b0;
  logic        pipe_filled = 1'b1;
  logic [3:0]  sig_detect = 4'hF;
  logic [3:0]  oos_flag = 4'h0;
  logic        trig_acc = 1'b0, evt_sent = 1'b0;
  logic [11:0] wof_hi = 12'd8, wof_lo = 12'd4;
  logic        fm_rdy, fm_bsy, fm_wof, fm_osy;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  fm_status_enc i_fm_status_enc (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .sw_rdy_set(sw_rdy_set),
    .sw_rdy_clr(sw_rdy_clr), .align_seen(align_seen), .pipe_filled(pipe_filled),
    .sig_detect(sig_detect), .oos_flag(oos_flag), .trig_acc(trig_acc),
    .evt_sent(evt_sent), .wof_hi(wof_hi), .wof_lo(wof_lo),
    .fm_rdy(fm_rdy), .fm_bsy(fm_bsy), .fm_wof(fm_wof), .fm_osy(fm_osy)
  );

  typedef struct packed {
    logic [2:0] cfg;
    logic       pipe;
    logic [3:0] oos;
    logic       e_rdy;
    logic       e_bsy;
    logic       e_osy;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b111, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0},
    '{3'b110, 1'b1, 4'h1, 1'b0, 1'b1, 1'b1},
    '{3'b101, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0},
    '{3'b011, 1'b1, 4'h8, 1'b0, 1'b1, 1'b1},
    '{3'b111, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0},
    '{3'b111, 1'b1, 4'h6, 1'b1, 1'b0, 1'b1},
    '{3'b000, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1},
    '{3'b111, 1'b1, 4'h0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk_rb(input string req, input logic r, input logic b);
    chk({req, " rdy"}, fm_rdy, r);
    chk({req, " bsy"}, fm_bsy, b);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk_rb("R1", 1'b0, 1'b1);
    chk("R1 wof", fm_wof, 1'b0);
    chk("R1 osy", fm_osy, 1'b0);
    rst = 1'b0;
    step();
    step();
    // R11 software bit and alignment cleared by reset
    chk_rb("R11", 1'b0, 1'b1);
    sw_rdy_set = 1'b1; step(); sw_rdy_set = 1'b0;
    chk_rb("R3 no align", 1'b0, 1'b1);
    align_seen = 1'b1; step(); align_seen = 1'b0;
    chk_rb("R2", 1'b1, 1'b0);
    step();
    chk_rb("R5 align held", 1'b1, 1'b0);

    // table walk: R2/R3 ready AND, R10 osy OR
    for (int i = 0; i < 8; i++) begin
      cfg_done = VECS[i].cfg;
      pipe_filled = VECS[i].pipe;
      oos_flag = VECS[i].oos;
      step();
      chk_rb("R2/R3 vec", VECS[i].e_rdy, VECS[i].e_bsy);
      chk("R10 vec", fm_osy, VECS[i].e_osy);
    end

    // R4 software bit
    sw_rdy_clr = 1'b1; step(); sw_rdy_clr = 1'b0;
    chk_rb("R4 clr", 1'b0, 1'b1);
    sw_rdy_set = 1'b1; sw_rdy_clr = 1'b1; step(); sw_rdy_clr = 1'b0; sw_rdy_set = 1'b0;
    chk_rb("R4 clr wins", 1'b0, 1'b1);
    sw_rdy_set = 1'b1; step(); sw_rdy_set = 1'b0;
    chk_rb("R4 set", 1'b1, 1'b0);
    step();
    chk_rb("R4 hold", 1'b1, 1'b0);

    // R7/R8/R9 occupancy and hysteresis
    wof_hi = 12'd3; wof_lo = 12'd2;
    trig_acc = 1'b1; step(); step(); trig_acc = 1'b0;
    chk("R8 below hi", fm_wof, 1'b0);
    trig_acc = 1'b1; evt_sent = 1'b1; step(); trig_acc = 1'b0; evt_sent = 1'b0;
    chk("R7 pair no change", fm_wof, 1'b0);
    trig_acc = 1'b1; step(); trig_acc = 1'b0;
    chk("R8 reach hi", fm_wof, 1'b1);
    evt_sent = 1'b1; step(); evt_sent = 1'b0;
    chk("R9 held in band", fm_wof, 1'b1);
    evt_sent = 1'b1; step(); evt_sent = 1'b0;
    chk("R9 below lo", fm_wof, 1'b0);
    evt_sent = 1'b1; step(); step(); evt_sent = 1'b0;
    wof_hi = 12'd1; wof_lo = 12'd1;
    step();
    chk("R7 floor at zero", fm_wof, 1'b0);
    trig_acc = 1'b1; step(); trig_acc = 1'b0;
    chk("R7 one after floor", fm_wof, 1'b1);
    evt_sent = 1'b1; step(); evt_sent = 1'b0;
    chk("R9 back to zero", fm_wof, 1'b0);
    wof_hi = 12'd4095; wof_lo = 12'd4095;
    trig_acc = 1'b1;
    repeat (4097) step();
    trig_acc = 1'b0;
    chk("R7 saturate", fm_wof, 1'b1);
    evt_sent = 1'b1; step(); evt_sent = 1'b0;
    chk("R7 max minus one", fm_wof, 1'b0);

    // R6 error latch
    sig_detect = 4'b1011; step(); sig_detect = 4'hF;
    chk_rb("R6 raise", 1'b1, 1'b1);
    sw_rdy_clr = 1'b1; step(); sw_rdy_clr = 1'b0;
    chk_rb("R6 over not-ready", 1'b1, 1'b1);
    sw_rdy_set = 1'b1; step(); sw_rdy_set = 1'b0;
    step();
    chk_rb("R6 sticky", 1'b1, 1'b1);

    // R11 reset clears error, bit and alignment
    rst = 1'b1; step(); rst = 1'b0;
    chk_rb("R1 again", 1'b0, 1'b1);
    step(); step();
    chk_rb("R11 busy after reset", 1'b0, 1'b1);
    sw_rdy_set = 1'b1; step(); sw_rdy_set = 1'b0;
    chk_rb("R5 align cleared", 1'b0, 1'b1);
    align_seen = 1'b1; step(); align_seen = 1'b0;
    chk_rb("R2 recover", 1'b1, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule